// File: doc/BRIEF.md
# Power-of-two clock divider with glitch-free output gating

This block turns a master clock into a slower square wave whose period is the master period times a power of two, picked by a small code. The divided wave leaves through an output stage that a pin, a software bit and a power-down input can open and close without ever producing a shortened pulse. It also holds the output off for a fixed warm-up time after power-on and after power-down ends. While it is off, a select bit chooses whether the pad is driven low or released.

The block runs on `clk_i`, a tick clock at twice the master frequency, so that one tick is half a master period. With code 0 the divided wave toggles on every tick, which is the master frequency itself. A control state machine has five states. SLEEP: power-down is active. WARM: the start-up hold-off is counting. IDLE: ready, with the gate closed. RUN: the gate is open and the divider runs. DRAIN: the gate has just closed and the current period is being finished. The transitions are: any state to SLEEP when `wake_i` is low; SLEEP to WARM when `wake_i` is high; WARM to RUN (gate open) or to IDLE (gate closed) when the hold-off expires; IDLE to RUN when the gate opens; RUN to DRAIN when the gate closes; DRAIN back to RUN when the gate reopens; DRAIN to IDLE when the wave is about to rise.

Top module: `pow2_div_gate`

## Requirements
- R1: The half period of `div_clk_o` while running is 2^x ticks for an applied code x, so the output frequency is the master frequency divided by 2^x; code 0 toggles on every tick.
- R2: A code above 8 acts as 8, so codes 9 to 15 all give a half period of 256 ticks.
- R3: The gate is open when `wake_i` is high and either `pin_gate_i` is 0 or `ena_pin_i` is 1. With `pin_gate_i` at 0 the level of `ena_pin_i` has no effect.
- R4: The output stays off through the hold-off. After reset is released it is off through the first 1023 rising edges and can start on edge 1024. After the edge that samples `wake_i` high in SLEEP, it is off for 1024 ticks and can start on the next edge after those.
- R5: When the gate opens, the edge that takes it (E0) starts the divider from a low phase. `div_clk_o` first rises at edge E0+2^x-1 and then toggles every 2^x edges, so the latency does not depend on how long the output was idle.
- R6: When the gate closes, the high pulse in progress and the following low phase both complete at full length. The output turns off at the edge where it would next have risen.
- R7: While off, `div_clk_o` is 0 and `pad_en_o` follows `park_low_i` directly (1 = driven low, 0 = high impedance). While running or draining, `pad_en_o` is 1 whatever the value of `park_low_i`.
- R8: `wake_i` low at an edge turns the output off and clears the divider at that edge, even in the middle of a pulse.
- R9: A code change while running takes effect at the next falling edge of `div_clk_o`. From that edge the output stays low for 2^x ticks of the new code, then continues at the new rate.
- R10: A code presented while the divider is stopped, at least one edge before the gate opens, is used from the first period of the next start.
- R11: During reset the block is in WARM with `div_clk_o` at 0 and `pad_en_o` equal to `park_low_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock at twice the master frequency |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wake_i | input | 1 | Power-down control, high = oscillator on |
| ena_pin_i | input | 1 | Hardware output enable |
| pin_gate_i | input | 1 | Software bit: 1 = output follows `ena_pin_i`, 0 = output always allowed |
| park_low_i | input | 1 | Off-state select: 1 = drive low, 0 = high impedance |
| code_i | input | 4 | Division exponent code |
| div_clk_o | output | 1 | Divided clock value for the pad |
| pad_en_o | output | 1 | Pad driver enable (tristate control) |

## Verification
Every control input is sampled at a rising edge, and its result is visible after that same edge, because state and divider phase both sit in single flops. The exception is `park_low_i`, which reaches `pad_en_o` with no register in between. The bench therefore books each expected output against an absolute edge index. Gate and power-down changes are due after the next edge. A start shows its first rise 2^x-1 edges after E0. A stop or a code change is due at the rising or falling boundary that the bench locates by stepping its own model of the wave. The hold-offs are due at edge 1024 after reset release and 1025 after the sampling of `wake_i`. The monitor compares at the falling clock edge, so each sample lies half a tick away from any edge where the design changes.

// File: rtl/pow2_gate_pkg.sv
`timescale 1ns/1ps
package pow2_gate_pkg;

    // Control states of the output gate
    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,   // power-down active, divider cleared
        ST_WARM  = 3'd1,   // start-up hold-off counting
        ST_IDLE  = 3'd2,   // ready, gate closed
        ST_RUN   = 3'd3,   // gate open, divider running
        ST_DRAIN = 3'd4    // gate closed, finishing the current period
    } gate_st_e;

endpackage

// File: rtl/pow2_code_clamp.sv
`timescale 1ns/1ps
module pow2_code_clamp #(
    parameter int CODE_W  = 4,
    parameter int MAX_EXP = 8,
    parameter int EXP_W   = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [EXP_W-1:0]  exp_o
);

    localparam int CODE_MAX = (1 << CODE_W) - 1;

    // Saturation logic exists only when the code can exceed the limit
    generate
        if (CODE_MAX > MAX_EXP) begin : g_sat
            always_comb begin
                if (code_i > CODE_W'(MAX_EXP))
                    exp_o = EXP_W'(MAX_EXP);
                else
                    exp_o = EXP_W'(code_i);
            end
        end else begin : g_pass
            always_comb exp_o = EXP_W'(code_i);
        end
    endgenerate

endmodule

// File: rtl/pow2_warm_timer.sv
`timescale 1ns/1ps
module pow2_warm_timer #(
    parameter int HOLD_TICKS = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic count_i,
    output logic done_o
);

    localparam int TW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(HOLD_TICKS - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (!count_i)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + TW'(1);
    end

    always_comb done_o = count_i && (cnt_q == LAST);

endmodule

// File: rtl/pow2_divider.sv
`timescale 1ns/1ps
module pow2_divider #(
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [EXP_W-1:0] code_i,
    output logic             phase_o,
    output logic             rise_next_o,
    output logic [EXP_W-1:0] code_o
);

    localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [EXP_W-1:0] code_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   last;
    logic             at_last;

    // Half period in ticks is 2^code; the counter wraps at span-1
    always_comb begin
        span    = (CNT_W+1)'(1) << code_q;
        last    = span - (CNT_W+1)'(1);
        at_last = ({1'b0, cnt_q} == last);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            code_q  <= '0;
        end else if (!run_i) begin
            // stopped: parked in a low phase, code follows the input
            cnt_q   <= '0;
            phase_q <= 1'b0;
            code_q  <= code_i;
        end else if (at_last) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
            // a new code is taken only at the falling boundary
            if (phase_q)
                code_q <= code_i;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        phase_o     = phase_q;
        rise_next_o = at_last && !phase_q;
        code_o      = code_q;
    end

endmodule

// File: rtl/pow2_gate_fsm.sv
`timescale 1ns/1ps
module pow2_gate_fsm
    import pow2_gate_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wake_i,
    input  logic     gate_open_i,
    input  logic     warm_done_i,
    input  logic     rise_next_i,
    output gate_st_e state_o,
    output logic     run_o,
    output logic     warm_o,
    output logic     live_o
);

    gate_st_e state_q;
    gate_st_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!wake_i) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP: state_d = ST_WARM;
                ST_WARM: begin
                    if (warm_done_i)
                        state_d = gate_open_i ? ST_RUN : ST_IDLE;
                end
                ST_IDLE: begin
                    if (gate_open_i)
                        state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!gate_open_i)
                        state_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (gate_open_i)
                        state_d = ST_RUN;
                    else if (rise_next_i)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_SLEEP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_WARM;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        run_o   = (state_d == ST_RUN) || (state_d == ST_DRAIN);
        warm_o  = (state_q == ST_WARM);
        live_o  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    end

endmodule

// File: rtl/pow2_div_gate.sv
`timescale 1ns/1ps
module pow2_div_gate
    import pow2_gate_pkg::*;
#(
    parameter int CODE_W         = 4,
    parameter int MAX_EXP        = 8,
    parameter int STARTUP_CYCLES = 512
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wake_i,
    input  logic              ena_pin_i,
    input  logic              pin_gate_i,
    input  logic              park_low_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              div_clk_o,
    output logic              pad_en_o
);

    // One tick is half a master period
    localparam int HOLD_TICKS = 2 * STARTUP_CYCLES;
    localparam int EXP_W      = $clog2(MAX_EXP + 1);

    logic             gate_open;
    logic [EXP_W-1:0] sat_code;
    logic [EXP_W-1:0] act_code;
    logic             phase;
    logic             rise_next;
    logic             warm_done;
    logic             div_run;
    logic             warm_cnt;
    logic             live;
    gate_st_e         state_q;

    always_comb gate_open = ena_pin_i || !pin_gate_i;

    pow2_code_clamp #(
        .CODE_W (CODE_W),
        .MAX_EXP(MAX_EXP),
        .EXP_W  (EXP_W)
    ) u_clamp (
        .code_i(code_i),
        .exp_o (sat_code)
    );

    pow2_warm_timer #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_warm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .count_i(warm_cnt),
        .done_o (warm_done)
    );

    pow2_divider #(
        .EXP_W  (EXP_W),
        .MAX_EXP(MAX_EXP)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (div_run),
        .code_i     (sat_code),
        .phase_o    (phase),
        .rise_next_o(rise_next),
        .code_o     (act_code)
    );

    pow2_gate_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wake_i     (wake_i),
        .gate_open_i(gate_open),
        .warm_done_i(warm_done),
        .rise_next_i(rise_next),
        .state_o    (state_q),
        .run_o      (div_run),
        .warm_o     (warm_cnt),
        .live_o     (live)
    );

    // Output stage: the pad value comes straight from the phase flop,
    // which the divider clears whenever it is stopped
    always_comb begin
        div_clk_o = phase;
        pad_en_o  = live || park_low_i;
    end

endmodule

// File: rtl/pow2_div_gate_chk.sv
`timescale 1ns/1ps
module pow2_div_gate_chk
    import pow2_gate_pkg::*;
#(
    parameter int MAX_EXP    = 8,
    parameter int EXP_W      = 4,
    parameter int HOLD_TICKS = 1024
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wake_i,
    input logic             ena_pin_i,
    input logic             pin_gate_i,
    input logic             div_clk_i,
    input gate_st_e         state_i,
    input logic [EXP_W-1:0] act_code_i
);

    int wcnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            wcnt <= 0;
        else if (state_i != ST_WARM)
            wcnt <= 0;
        else
            wcnt <= wcnt + 1;
    end

    assert_sat_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_code_i <= EXP_W'(MAX_EXP));

    assert_gate_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_IDLE && wake_i && (ena_pin_i || !pin_gate_i)) |=> (state_i == ST_RUN));

    assert_holdoff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_WARM && wake_i && wcnt != HOLD_TICKS - 1) |=> (state_i == ST_WARM));

    assert_clean_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_i) != ST_RUN && $past(state_i) != ST_DRAIN && state_i == ST_RUN
         && act_code_i != '0) |-> !div_clk_i);

    assert_drain_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_i) == ST_DRAIN && state_i == ST_IDLE) |-> (!$past(div_clk_i) && !div_clk_i));

    assert_sleep_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wake_i |=> (!div_clk_i && state_i == ST_SLEEP));

endmodule

bind pow2_div_gate pow2_div_gate_chk #(
    .MAX_EXP   (MAX_EXP),
    .EXP_W     (EXP_W),
    .HOLD_TICKS(HOLD_TICKS)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wake_i    (wake_i),
    .ena_pin_i (ena_pin_i),
    .pin_gate_i(pin_gate_i),
    .div_clk_i (div_clk_o),
    .state_i   (state_q),
    .act_code_i(act_code)
);

// File: tb/sim_pow2_div_gate.sv
`timescale 1ns/1ps
module sim_pow2_div_gate;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wake;
    logic       ena_pin;
    logic       pin_gate;
    logic       park_low;
    logic [3:0] code;
    logic       div_clk;
    logic       pad_en;

    always #2.5 clk = ~clk;

    pow2_div_gate u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wake_i    (wake),
        .ena_pin_i (ena_pin),
        .pin_gate_i(pin_gate),
        .park_low_i(park_low),
        .code_i    (code),
        .div_clk_o (div_clk),
        .pad_en_o  (pad_en)
    );

    typedef struct {
        int    cyc;
        bit    ck;
        bit    en;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc      = 0;
    int   checks   = 0;
    int   fails    = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares booked samples half a tick after each edge
    always @(negedge clk) begin
        exp_t e;
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            e = sbq.pop_front();
            checks++;
            if (e.cyc < cyc) begin
                fails++;
                $display("FAIL %s: slot %0d missed, actual cycle %0d expected cycle %0d",
                         e.tag, e.cyc, cyc, e.cyc);
            end else if (div_clk !== e.ck || pad_en !== e.en) begin
                fails++;
                $display("FAIL %s at cycle %0d: div_clk=%b pad_en=%b, expected div_clk=%b pad_en=%b",
                         e.tag, cyc, div_clk, pad_en, e.ck, e.en);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(int c);
        while (cyc < c) step();
    endtask

    task automatic push(int c, bit ck, bit en, string tag);
        exp_t e;
        e.cyc = c;
        e.ck  = ck;
        e.en  = en;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // Expected wave: a is the edge after which the wave sits at the start of a low phase
    function automatic bit wave(int c, int a, int x);
        return bit'(((c - a) >> x) & 1);
    endfunction

    task automatic push_off(int c0, int c1, bit park, string tag);
        for (int c = c0; c <= c1; c++) push(c, 1'b0, park, tag);
    endtask

    task automatic push_run(int c0, int c1, int a, int x, string tag);
        for (int c = c0; c <= c1; c++) push(c, wave(c, a, x), 1'b1, tag);
    endtask

    initial begin
        int n, m, q, a, fe, re;
        rst_n    = 1'b0;
        wake     = 1'b1;
        ena_pin  = 1'b0;
        pin_gate = 1'b0;
        park_low = 1'b1;
        code     = 4'd0;
        repeat (3) step();
        push(cyc, 1'b0, 1'b1, "R11 reset state");
        step();

        // Power-up hold-off, then code 0 with the pin ignored (pin_gate 0, pin low)
        n = cyc;
        rst_n = 1'b1;
        push_off(n + 1, n + 1023, 1'b1, "R4 power-up hold-off");
        a = n + 1023;
        push_run(n + 1024, n + 1031, a, 0, "R1 R3 undivided start, pin ignored");
        wait_until(n + 1031);

        // Code change while running: applies at the next falling edge
        n = cyc;
        code = 4'd3;
        fe = n + 1;
        for (int c = n + 1; c < n + 64; c++) begin
            if (wave(c - 1, a, 0) && !wave(c, a, 0)) begin
                fe = c;
                break;
            end
        end
        push_run(n + 1, fe - 1, a, 0, "R9 old rate until boundary");
        a = fe;
        push_run(fe, fe + 39, a, 3, "R9 R1 new code 3");
        wait_until(fe + 39);

        // Gate closed through the pin: drain to the end of the low phase, then hi-Z
        n = cyc;
        park_low = 1'b0;
        pin_gate = 1'b1;
        ena_pin  = 1'b0;
        re = n + 2;
        for (int c = n + 2; c < n + 64; c++) begin
            if (!wave(c - 1, a, 3) && wave(c, a, 3)) begin
                re = c;
                break;
            end
        end
        push_run(n + 1, re - 1, a, 3, "R6 R7 drain keeps pad driven");
        push_off(re, re + 20, 1'b0, "R6 R3 R7 stopped, high impedance");
        wait_until(re + 20);

        // Saturated code loaded while stopped, then the pin opens the gate
        n = cyc;
        code = 4'd12;
        step();
        m = cyc;
        ena_pin = 1'b1;
        push_off(n + 1, m, 1'b0, "R10 idle before start");
        a = m;
        push_run(m + 1, m + 300, a, 8, "R2 R5 R10 code 12 runs as 8");
        wait_until(m + 300);

        // Power-down in the middle of a high phase
        n = cyc;
        wake = 1'b0;
        push_off(n + 1, n + 3, 1'b0, "R8 power-down stops output");
        wait_until(n + 4);
        park_low = 1'b1;
        push_off(n + 4, n + 8, 1'b1, "R7 off state driven low");
        wait_until(n + 8);

        // Leave power-down: hold-off again, divider restarts from a fresh period
        q = cyc;
        wake = 1'b1;
        push_off(q + 1, q + 1024, 1'b1, "R4 wake hold-off");
        a = q + 1024;
        push_run(q + 1025, q + 1300, a, 8, "R4 R5 R8 restart after wake");
        wait_until(q + 1302);

        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d booked samples left, expected 0", sbq.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run still active at cycle %0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule